// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is an I2C bus master that only writes. It sends a start condition, then a 7-bit slave address with a write bit of 0, then any number of data bytes, and ends with a stop condition or a repeated start. A CPU writes bytes into a single data register and sets control bits. The controller copies each byte into a shift register and sends it most significant bit first. It samples the slave's acknowledge and reports what happened through status flags and an interrupt.

The data register is freed early. As soon as the first bit of the current byte has been clocked out, the register reads as empty again. Software can then load the next byte while the other seven bits are still going out. If the register is still empty when an acknowledged byte ends, the controller holds SCL low and waits. After a not-acknowledge, the controller also holds SCL low, and it resumes only when software sets stop and flushes the buffered byte. Both bus lines are open-drain. The block drives each line low through an enable and reads SDA back. Each SCL half-period lasts a fixed number of system clocks, set by a parameter.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset, the enable, interrupt-enable, start and stop bits read 0. The data register reads empty, ACK and NACK are 0, irq is 0, and neither line is driven.
- R2: While the enable bit (ctrl bit 0) is 0, neither line is driven and a pending start bit (ctrl bit 2) stays pending.
- R3: irq is high exactly when the block is enabled and either the NACK flag is set or the data register is empty with the interrupt-enable bit (ctrl bit 1) set.
- R4: Setting start with a byte in the data register produces an SDA fall while SCL is high, then that byte most significant bit first. The start bit clears itself once the start condition has been driven.
- R5: The empty flag sets again when the first bit of a byte completes, while the remaining bits are still shifting.
- R6: A low SDA in the ninth SCL high period sets ACK. The next buffered byte then follows without a stop.
- R7: A high SDA in that period sets NACK, clears ACK and raises irq. SCL is then held low: stop alone does not release it. Stop together with flush (ctrl bit 4) sends a stop, leaves the register empty and clears both stop and NACK.
- R8: Stop (ctrl bit 3), when set, ends the transfer after the current acknowledged byte with an SDA rise while SCL is high, and then clears itself.
- R9: Setting start together with a new byte during a transfer produces a repeated start after the current byte, followed by that byte.
- R10: If an acknowledged byte ends with the register empty and nothing pending, SCL is held low until a byte is written. The transfer then resumes.
- R11: SDA changes only while SCL is low, except at start and stop conditions. Every data and acknowledge SCL high phase lasts HALF_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Byte to transmit (first byte: address in bits 7:1, bit 0 = 0) |
| ctrl_we | input | 1 | Write strobe for the control bits |
| ctrl_wdata | input | 5 | {flush, stop, start, int enable, enable} |
| ctrl_q | output | 4 | Readback {stop, start, int enable, enable} |
| tx_empty | output | 1 | Data register empty |
| ack_seen | output | 1 | Last byte acknowledged |
| nack_seen | output | 1 | Last byte not acknowledged |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench targets four corner cases.

- **Early empty flag.** It checks that the empty flag rises while the current byte is still only partly on the bus. A controller that freed the register only at the byte's end would fail that check.
- **Stalls.** It stalls the bus twice: once with no byte buffered after an ACK, and once after a NACK. In both cases it verifies that SCL stays low. A controller that ran on after a NACK, or accepted stop without a flush, would show an extra byte or an early stop.
- **Repeated start.** It checks that the controller emits a fresh start condition. A missing repeated start shows up as a stray byte in the scoreboard.
- **Timing.** It measures every SCL high phase against HALF_CYCLES. An off-by-one divider is reported as a wrong width.

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
  parameter int HALF_CYCLES = 8,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic          ctrl_we,
  input  logic [4:0]    ctrl_wdata,
  output logic [3:0]    ctrl_q,
  output logic          tx_empty,
  output logic          ack_seen,
  output logic          nack_seen,
  output logic          irq,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BW = $clog2(DW);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_ACK_LOW, ST_ACK_HIGH, ST_NEXT,
    ST_NHOLD, ST_STOP_LOW, ST_STOP_HIGH, ST_STOP_DONE, ST_RS_LOW, ST_RS_HIGH
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] data_q, shift_q;
  logic          en_q, txie_q, start_q, stop_q, empty_q, ack_q, nack_q;
  logic          timed, half_done;

  assign timed = state inside {ST_START, ST_LOW, ST_HIGH, ST_ACK_LOW, ST_ACK_HIGH,
                               ST_STOP_LOW, ST_STOP_HIGH, ST_STOP_DONE, ST_RS_LOW, ST_RS_HIGH};
  assign half_done = timed && (cnt == CW'(HALF_CYCLES - 1));

  assign scl_oe = state inside {ST_LOW, ST_ACK_LOW, ST_NEXT, ST_NHOLD, ST_STOP_LOW, ST_RS_LOW};
  assign sda_oe = ((state inside {ST_LOW, ST_HIGH}) && !shift_q[DW-1]) ||
                  (state inside {ST_START, ST_STOP_LOW, ST_STOP_HIGH});

  assign ctrl_q    = {stop_q, start_q, txie_q, en_q};
  assign tx_empty  = empty_q;
  assign ack_seen  = ack_q;
  assign nack_seen = nack_q;
  assign irq       = en_q && ((txie_q && empty_q) || nack_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      data_q  <= '0;
      shift_q <= '0;
      en_q    <= 1'b0;
      txie_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      empty_q <= 1'b1;
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      cnt <= (!en_q || !timed || half_done) ? '0 : cnt + 1'b1;
      if (!en_q) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:
            if (stop_q) stop_q <= 1'b0;
            else if (start_q && !empty_q) state <= ST_START;
          ST_START:
            if (half_done) begin
              shift_q <= data_q;
              start_q <= 1'b0;
              bit_idx <= '0;
              state   <= ST_LOW;
            end
          ST_LOW:
            if (half_done) state <= ST_HIGH;
          ST_HIGH:
            if (half_done) begin
              if (bit_idx == '0) empty_q <= 1'b1;
              if (bit_idx == BW'(DW - 1)) begin
                state <= ST_ACK_LOW;
              end else begin
                shift_q <= shift_q << 1;
                bit_idx <= bit_idx + 1'b1;
                state   <= ST_LOW;
              end
            end
          ST_ACK_LOW:
            if (half_done) state <= ST_ACK_HIGH;
          ST_ACK_HIGH:
            if (half_done) begin
              if (!sda_in) begin
                ack_q <= 1'b1;
                state <= ST_NEXT;
              end else begin
                ack_q  <= 1'b0;
                nack_q <= 1'b1;
                state  <= ST_NHOLD;
              end
            end
          ST_NEXT:
            if (stop_q) state <= ST_STOP_LOW;
            else if (start_q && !empty_q) state <= ST_RS_LOW;
            else if (!empty_q) begin
              shift_q <= data_q;
              bit_idx <= '0;
              state   <= ST_LOW;
            end
          ST_NHOLD:
            if (stop_q && empty_q) state <= ST_STOP_LOW;
          ST_STOP_LOW:
            if (half_done) state <= ST_STOP_HIGH;
          ST_STOP_HIGH:
            if (half_done) state <= ST_STOP_DONE;
          ST_STOP_DONE:
            if (half_done) begin
              stop_q <= 1'b0;
              nack_q <= 1'b0;
              state  <= ST_IDLE;
            end
          ST_RS_LOW:
            if (half_done) state <= ST_RS_HIGH;
          ST_RS_HIGH:
            if (half_done) state <= ST_START;
          default: state <= ST_IDLE;
        endcase
      end
      if (ctrl_we) begin
        en_q    <= ctrl_wdata[0];
        txie_q  <= ctrl_wdata[1];
        start_q <= ctrl_wdata[2];
        stop_q  <= ctrl_wdata[3];
        if (ctrl_wdata[4]) empty_q <= 1'b1;
      end
      if (data_we) begin
        data_q  <= data_wdata;
        empty_q <= 1'b0;
      end
    end
  end

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q)) |-> (!scl_oe && !sda_oe)) else $error("off drive"); // R2

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_q) && !$past(ctrl_we)) |-> (state == ST_LOW && bit_idx == '0)) else $error("start clr"); // R4

  AST_EMPTY_AFTER_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(empty_q) && !$past(ctrl_we)) |-> (state == ST_LOW && bit_idx == BW'(1))) else $error("empty"); // R5

  AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_q) |-> (!ack_q && state == ST_NHOLD && scl_oe)) else $error("nack"); // R7

  AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_q) && !$past(ctrl_we)) |-> (state == ST_IDLE && !nack_q)) else $error("stop clr"); // R8

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_oe)) else $error("sda moved"); // R11
endmodule

// File: tb/test_i2c_byte_tx.sv
module test_i2c_byte_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       data_we = 1'b0, ctrl_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic [4:0] ctrl_wdata = '0;
  logic [3:0] ctrl_q;
  logic       tx_empty, ack_seen, nack_seen, irq, scl_oe, sda_oe, sda_in;
  logic       pull = 1'b0;

  int checks = 0, errors = 0, ev_cnt = 0;
  logic [9:0] exp_q[$];
  bit         ack_plan[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = ~(sda_oe | pull);

  i2c_byte_tx #(.HALF_CYCLES(HALF), .DW(8)) i_i2c_byte_tx (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .tx_empty(tx_empty), .ack_seen(ack_seen), .nack_seen(nack_seen), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver side
  task automatic wr_data(logic [7:0] b);
    @(negedge clk); data_we = 1'b1; data_wdata = b;
    @(negedge clk); data_we = 1'b0;
  endtask
  task automatic wr_ctrl(logic [4:0] c);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = c;
    @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic expect_ev(logic [1:0] kind, logic [7:0] b);
    exp_q.push_back({kind, b});
  endtask
  task automatic wait_empty();
    for (int k = 0; k < 3000 && !tx_empty; k++) @(negedge clk);
  endtask
  task automatic wait_stop_clear();
    for (int k = 0; k < 3000 && ctrl_q[3]; k++) @(negedge clk);
  endtask

  // monitor side: bus decoder, slave acknowledge, scoreboard
  logic       p_scl = 1'b1, p_sda = 1'b1, hi_chk = 1'b0;
  logic [7:0] rx = '0;
  int         bitcnt = 0, hi_cnt = 0;

  task automatic observe(logic [1:0] kind, logic [7:0] b);
    logic [9:0] e;
    string tag;
    tag = (kind == 2'd3) ? "R8" : "R4";
    ev_cnt++;
    if (exp_q.size() == 0) begin
      chk(1'b0, tag, "unexpected bus event", {kind, b}, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == {kind, b}, tag, "bus event {kind,byte}", {kind, b}, e);
    end
  endtask

  always @(negedge clk) begin
    logic scl, sda;
    scl = ~scl_oe;
    sda = sda_in;
    if (!rst_n) begin
      p_scl = 1'b1; p_sda = 1'b1;
    end else begin
      if (p_scl && scl && p_sda && !sda) begin
        observe(2'd1, 8'h00); bitcnt = 0; hi_chk = 1'b0;
      end else if (p_scl && scl && !p_sda && sda) begin
        observe(2'd3, 8'h00); bitcnt = 0; hi_chk = 1'b0;
      end
      if (!p_scl && scl) begin
        hi_cnt = 1; hi_chk = 1'b1;
        if (bitcnt < 8) begin
          rx = {rx[6:0], sda};
          bitcnt++;
          if (bitcnt == 8) observe(2'd2, rx);
        end else begin
          bitcnt = 9;
        end
      end else if (p_scl && scl) begin
        hi_cnt++;
      end
      if (p_scl && !scl) begin
        if (hi_chk) chk(hi_cnt == HALF, "R11", "SCL high width", hi_cnt, HALF);
        hi_chk = 1'b0;
        if (bitcnt == 8) pull = ack_plan.size() ? ack_plan.pop_front() : 1'b0;
        else if (bitcnt == 9) begin pull = 1'b0; bitcnt = 0; end
      end
      p_scl = scl; p_sda = sda;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_q == 4'h0, "R1", "ctrl after reset", ctrl_q, 0);
    chk(tx_empty && !ack_seen && !nack_seen && !irq, "R1", "status after reset",
        {tx_empty, ack_seen, nack_seen, irq}, 4'b1000);
    chk(!scl_oe && !sda_oe, "R1", "lines after reset", {scl_oe, sda_oe}, 0);

    // R2 disabled: start stays pending, bus idle
    wr_data(8'hA4);
    wr_ctrl(5'b00100);
    repeat (100) @(negedge clk);
    chk(ev_cnt == 0 && !scl_oe && !sda_oe, "R2", "bus activity while off", ev_cnt, 0);
    chk(ctrl_q[2], "R2", "start pending while off", ctrl_q[2], 1);
    wr_ctrl(5'b10000);
    chk(tx_empty, "R7", "flush empties register", tx_empty, 1);

    // R3 interrupt
    wr_ctrl(5'b00011);
    chk(irq, "R3", "irq with empty and int enable", irq, 1);
    wr_data(8'hA4);
    chk(!irq, "R3", "irq after data write", irq, 0);

    // R4/R5/R6 address then data bytes, all acknowledged
    expect_ev(2'd1, 8'h00); expect_ev(2'd2, 8'hA4); ack_plan.push_back(1'b1);
    wr_ctrl(5'b00111);
    wait_empty();
    chk(ctrl_q[2] == 1'b0, "R4", "start self-clear", ctrl_q[2], 0);
    chk(exp_q.size() == 1 && scl_oe, "R5", "empty while byte shifting", exp_q.size(), 1);
    chk(irq, "R3", "irq on early empty", irq, 1);
    expect_ev(2'd2, 8'h3C); ack_plan.push_back(1'b1);
    wr_data(8'h3C);
    wait_empty();
    chk(ack_seen, "R6", "ack after address", ack_seen, 1);
    expect_ev(2'd2, 8'hF1); ack_plan.push_back(1'b1);
    wr_data(8'hF1);
    wait_empty();

    // R10 stall with empty register
    repeat (20 * HALF) @(negedge clk);
    lowcnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (scl_oe) lowcnt++; end
    chk(lowcnt == 40, "R10", "SCL held low when empty", lowcnt, 40);
    chk(exp_q.size() == 0, "R10", "no bus events during stall", exp_q.size(), 0);
    expect_ev(2'd2, 8'h55); ack_plan.push_back(1'b1);
    wr_data(8'h55);
    wait_empty();
    expect_ev(2'd3, 8'h00);
    wr_ctrl(5'b01001);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    chk(ctrl_q[3] == 1'b0 && exp_q.size() == 0, "R8", "stop sent and cleared", exp_q.size(), 0);
    chk(!scl_oe && !sda_oe, "R8", "lines released after stop", {scl_oe, sda_oe}, 0);

    // R9 repeated start
    wr_ctrl(5'b00011);
    expect_ev(2'd1, 8'h00); expect_ev(2'd2, 8'h92); ack_plan.push_back(1'b1);
    wr_data(8'h92);
    wr_ctrl(5'b00111);
    wait_empty();
    expect_ev(2'd1, 8'h00); expect_ev(2'd2, 8'h93); ack_plan.push_back(1'b1);
    wr_data(8'h93);
    wr_ctrl(5'b00111);
    wait_empty();
    expect_ev(2'd3, 8'h00);
    wr_ctrl(5'b01001);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "repeated start sequence complete", exp_q.size(), 0);

    // R7 not-acknowledge
    wr_ctrl(5'b00011);
    expect_ev(2'd1, 8'h00); expect_ev(2'd2, 8'h40); ack_plan.push_back(1'b0);
    wr_data(8'h40);
    wr_ctrl(5'b00111);
    wait_empty();
    wr_data(8'h11);
    for (int k = 0; k < 3000 && !nack_seen; k++) @(negedge clk);
    chk(nack_seen && !ack_seen, "R7", "nack flags", {nack_seen, ack_seen}, 2'b10);
    chk(irq, "R7", "irq on nack", irq, 1);
    wr_ctrl(5'b01001);
    repeat (20 * HALF) @(negedge clk);
    chk(scl_oe && ctrl_q[3] && nack_seen, "R7", "stop alone holds bus",
        {scl_oe, ctrl_q[3], nack_seen}, 3'b111);
    expect_ev(2'd3, 8'h00);
    wr_ctrl(5'b11001);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    chk(!nack_seen && tx_empty && exp_q.size() == 0, "R7", "stop+flush completes",
        {nack_seen, tx_empty, exp_q.size() == 0}, 3'b011);
    finish_run();
  end
endmodule